// File: doc/BRIEF.md
# Configurable Logic Cell

This block is a small programmable logic element for an on-chip control fabric. It watches a 32-line source bus that carries pin inputs and the outputs of other peripherals. It builds four gate signals from that bus and combines them with one of several selectable functions, either stateless or stateful. The result goes through an output polarity inverter. That inverted-or-not value is the cell's internal output, so it can feed the source bus of another cell to form a chain. The same value also drives a pin output that is gated by an enable bit.

Each of the four gates has eight candidate lines, and each candidate picks any bus line through its own select field. Per candidate, the true form, the inverted form, both or neither can be enabled. A gate ORs its enabled terms and can then invert the result. Sequential functions run on the system clock: they watch gate 1 for a rising level and treat that as their clock event. Rising and falling transitions of the output raise one-cycle pulses and latched flags that stay set until they are cleared. All configuration is held on static inputs.

Top module: `lcell_top`

## Requirements
- R1: Candidate c of gate k (k = 0..3, c = 0..7) takes the bus line whose number is in the 5-bit field `cfg_sel[(k*8+c)*5 +: 5]`. Gate k is the function input g(k+1).
- R2: Each candidate gives a true term when `cfg_en_true[k*8+c]` is set and an inverted term when `cfg_en_inv[k*8+c]` is set. The gate is the OR of all its enabled terms, so a candidate with both forms enabled forces the gate to 1.
- R3: A gate with no term enabled gives 0. Bit k of `cfg_gate_pol` then inverts gate k.
- R4: Mode encodings: 0 gives (g1&g2)|(g3&g4), 1 gives (g1|g2)^(g3|g4), 2 gives g1&g2&g3&g4. The reserved codes 6 and 7 give 0. The output follows the inputs without a clock.
- R5: Mode 3 is a set/reset store evaluated at every clock. Reset is g3|g4 and set is g1|g2. Reset wins, and the value holds when neither is active.
- R6: Mode 4 is a D store. At a clock where g1 has gone from 0 to 1 it takes g2. g3 clears it and g4 sets it at any clock, and g3 has priority over g4, which has priority over the data load.
- R7: Mode 5 is a JK store with J=g2 and K=g4. On a g1 rising it sets (J only), clears (K only), toggles (both) or holds (neither). g3 clears it at any clock, with priority.
- R8: `cell_out` is the function result XOR `cfg_out_pol`. `pin_out` equals `cell_out` when `cfg_pin_oe` is 1 and is 0 otherwise.
- R9: A 0-to-1 change of `cell_out` raises `rise_pulse` for exactly the one cycle after the clock edge that sees it, and only when `cfg_rise_en` is 1. `fall_pulse` does the same for a 1-to-0 change under `cfg_fall_en`.
- R10: Each flag sets with its pulse and stays at 1 until its clear input is 1 at a clock edge. If a new edge arrives in the same cycle as a clear, the flag stays set.
- R11: Reset clears the stored state, both pulses and both flags. The first clock after reset counts neither as an output edge nor as a g1 rising, whatever the signal levels are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_bus | input | 32 | Source lines from pins and peripherals |
| cfg_sel | input | 160 | Bus line select, 5 bits per candidate |
| cfg_en_true | input | 32 | True-form enables, 8 per gate |
| cfg_en_inv | input | 32 | Inverted-form enables, 8 per gate |
| cfg_gate_pol | input | 4 | Per-gate result inversion |
| cfg_mode | input | 3 | Logic function select |
| cfg_out_pol | input | 1 | Output polarity inversion |
| cfg_pin_oe | input | 1 | Pin output enable |
| cfg_rise_en | input | 1 | Rising-edge event enable |
| cfg_fall_en | input | 1 | Falling-edge event enable |
| clr_rise | input | 1 | Clears the rising flag |
| clr_fall | input | 1 | Clears the falling flag |
| cell_out | output | 1 | Post-polarity cell output |
| pin_out | output | 1 | Enable-gated pin output |
| rise_pulse | output | 1 | One-cycle rising-edge event |
| fall_pulse | output | 1 | One-cycle falling-edge event |
| rise_flag | output | 1 | Latched rising-edge flag |
| fall_flag | output | 1 | Latched falling-edge flag |

## Verification
The bench drives gates that have no term enabled and candidates that have both forms enabled. A gate that inverted before the OR, or that left an empty gate floating to 1, would give the wrong AND4 result. It holds g1 high across a data change to prove that the D and JK stores load only on a g1 rising and give clear priority over set. A store that used g1's level would load twice. It leaves reset with the output already high and with g1 already high, which catches a design that reports a false edge or a false load on the first clock. It also sends a new edge in the same cycle as a clear, where a design that let the clear win would drop the event.

// File: rtl/lcell_pkg.sv
package lcell_pkg;

   localparam int unsigned NGATES = 4;

   typedef enum logic [2:0] {
      MODE_AND_OR = 3'd0,
      MODE_OR_XOR = 3'd1,
      MODE_AND4   = 3'd2,
      MODE_SR     = 3'd3,
      MODE_DFF    = 3'd4,
      MODE_JK     = 3'd5,
      MODE_RSV6   = 3'd6,
      MODE_RSV7   = 3'd7
   } lc_mode_e;

   function automatic logic mode_is_seq(lc_mode_e m);
      return (m == MODE_SR) || (m == MODE_DFF) || (m == MODE_JK);
   endfunction

endpackage

// File: rtl/lcell_srcmux.sv
module lcell_srcmux #(
   parameter int unsigned SRC_W = 32,
   parameter int unsigned NCAND = 8,
   localparam int unsigned SELW = $clog2(SRC_W)
) (
   input  logic [SRC_W-1:0]      src_bus,
   input  logic [NCAND*SELW-1:0] sel,
   output logic [NCAND-1:0]      cand
);

   for (genvar c = 0; c < NCAND; c++) begin : g_cand
      logic [SELW-1:0] idx;
      assign idx     = sel[c*SELW +: SELW];
      assign cand[c] = src_bus[idx];
   end

endmodule

// File: rtl/lcell_gate.sv
module lcell_gate #(
   parameter int unsigned NCAND = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NCAND-1:0] cand,
   input  logic [NCAND-1:0] en_true,
   input  logic [NCAND-1:0] en_inv,
   input  logic             pol,
   output logic             gate_out
);

   logic [NCAND-1:0] term;

   for (genvar i = 0; i < NCAND; i++) begin : g_term
      assign term[i] = (cand[i] & en_true[i]) | (~cand[i] & en_inv[i]);
   end

   logic any_term;
   assign any_term = |term;
   assign gate_out = any_term ^ pol;

   // R3: no terms -> only the polarity bit shows
   a_r3_empty_gate: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_true == '0) && (en_inv == '0)) |-> (gate_out == pol));

   // R2: both forms of every candidate -> OR is always true
   a_r2_both_forms: assert property (@(posedge clk) disable iff (!rst_n)
      ((en_true == '1) && (en_inv == '1)) |-> (gate_out == !pol));

endmodule

// File: rtl/lcell_func.sv
module lcell_func
   import lcell_pkg::*;
(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NGATES-1:0] g,
   input  logic [2:0]        mode,
   output logic              raw
);

   lc_mode_e mode_e;
   assign mode_e = lc_mode_e'(mode);

   // stateless functions
   logic comb_val;
   always_comb begin
      case (mode_e)
         MODE_AND_OR: comb_val = (g[0] & g[1]) | (g[2] & g[3]);
         MODE_OR_XOR: comb_val = (g[0] | g[1]) ^ (g[2] | g[3]);
         MODE_AND4:   comb_val = &g;
         default:     comb_val = 1'b0;
      endcase
   end

   // stateful functions, g1 rising treated as clock event
   logic q, q_nx, g1_prev, armed;
   logic clk_ev;
   assign clk_ev = armed & g[0] & ~g1_prev;

   always_comb begin
      q_nx = q;
      case (mode_e)
         MODE_SR: begin
            if (g[2] | g[3])      q_nx = 1'b0;
            else if (g[0] | g[1]) q_nx = 1'b1;
         end
         MODE_DFF: begin
            if (g[2])        q_nx = 1'b0;
            else if (g[3])   q_nx = 1'b1;
            else if (clk_ev) q_nx = g[1];
         end
         MODE_JK: begin
            if (g[2]) q_nx = 1'b0;
            else if (clk_ev) begin
               case ({g[1], g[3]})
                  2'b10:   q_nx = 1'b1;
                  2'b01:   q_nx = 1'b0;
                  2'b11:   q_nx = ~q;
                  default: q_nx = q;
               endcase
            end
         end
         default: q_nx = q;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q       <= 1'b0;
         g1_prev <= 1'b0;
         armed   <= 1'b0;
      end else begin
         q       <= q_nx;
         g1_prev <= g[0];
         armed   <= 1'b1;
      end
   end

   assign raw = mode_is_seq(mode_e) ? q : comb_val;

   // R6: D store holds without a g1 rising or a set/clear
   a_r6_dff_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_e == MODE_DFF) && !g[2] && !g[3] && !(g[0] && !g1_prev)) |=> $stable(q));

   // R7: clear input of the JK/D stores wins
   a_r7_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (((mode_e == MODE_DFF) || (mode_e == MODE_JK)) && g[2]) |=> (q == 1'b0));

   // R5: set/reset store, reset side dominates
   a_r5_sr_reset_wins: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_e == MODE_SR) && (g[2] || g[3])) |=> (q == 1'b0));

   // R5: set/reset store holds when idle
   a_r5_sr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      ((mode_e == MODE_SR) && (g == '0)) |=> $stable(q));

endmodule

// File: rtl/lcell_edge.sv
module lcell_edge #(
   parameter bit RISING = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig,
   input  logic en,
   input  logic clr,
   output logic pulse,
   output logic flag
);

   logic sig_prev, armed, seen, hit;

   if (RISING) begin : g_rise
      assign seen = sig & ~sig_prev;
   end else begin : g_fall
      assign seen = ~sig & sig_prev;
   end

   assign hit = armed & en & seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_prev <= 1'b0;
         armed    <= 1'b0;
         pulse    <= 1'b0;
         flag     <= 1'b0;
      end else begin
         sig_prev <= sig;
         armed    <= 1'b1;
         pulse    <= hit;
         flag     <= hit | (flag & ~clr);
      end
   end

   // R9: an event lasts one cycle
   a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |=> !pulse);

   // R9: disabled direction gives no event
   a_r9_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !en |=> !pulse);

   // R10: every event leaves the flag set
   a_r10_pulse_flag: assert property (@(posedge clk) disable iff (!rst_n)
      pulse |-> flag);

   // R10: flag holds until cleared
   a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (flag && !clr) |=> flag);

   // R10: clear without a possible event empties the flag
   a_r10_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !en) |=> !flag);

endmodule

// File: rtl/lcell_top.sv
module lcell_top
   import lcell_pkg::*;
#(
   parameter int unsigned SRC_W = 32,
   parameter int unsigned NCAND = 8,
   localparam int unsigned SELW = $clog2(SRC_W),
   localparam int unsigned SEL_TOT = NGATES*NCAND*SELW,
   localparam int unsigned EN_TOT = NGATES*NCAND
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [SRC_W-1:0]   src_bus,
   input  logic [SEL_TOT-1:0] cfg_sel,
   input  logic [EN_TOT-1:0]  cfg_en_true,
   input  logic [EN_TOT-1:0]  cfg_en_inv,
   input  logic [NGATES-1:0]  cfg_gate_pol,
   input  logic [2:0]         cfg_mode,
   input  logic               cfg_out_pol,
   input  logic               cfg_pin_oe,
   input  logic               cfg_rise_en,
   input  logic               cfg_fall_en,
   input  logic               clr_rise,
   input  logic               clr_fall,
   output logic               cell_out,
   output logic               pin_out,
   output logic               rise_pulse,
   output logic               fall_pulse,
   output logic               rise_flag,
   output logic               fall_flag
);

   if (SRC_W < 2 || (1 << SELW) != SRC_W) begin : g_bad_src
      $error("lcell_top: SRC_W must be a power of two of at least 2");
   end
   if (NCAND < 1) begin : g_bad_cand
      $error("lcell_top: NCAND must be at least 1");
   end

   logic [NGATES-1:0] gate_v;

   for (genvar k = 0; k < NGATES; k++) begin : g_gate
      logic [NCAND-1:0] cand;

      lcell_srcmux #(.SRC_W(SRC_W), .NCAND(NCAND)) u_mux (
         .src_bus (src_bus),
         .sel     (cfg_sel[k*NCAND*SELW +: NCAND*SELW]),
         .cand    (cand)
      );

      lcell_gate #(.NCAND(NCAND)) u_gate (
         .clk      (clk),
         .rst_n    (rst_n),
         .cand     (cand),
         .en_true  (cfg_en_true[k*NCAND +: NCAND]),
         .en_inv   (cfg_en_inv[k*NCAND +: NCAND]),
         .pol      (cfg_gate_pol[k]),
         .gate_out (gate_v[k])
      );
   end

   logic func_raw;

   lcell_func u_func (
      .clk   (clk),
      .rst_n (rst_n),
      .g     (gate_v),
      .mode  (cfg_mode),
      .raw   (func_raw)
   );

   assign cell_out = func_raw ^ cfg_out_pol;
   assign pin_out  = cfg_pin_oe & cell_out;

   lcell_edge #(.RISING(1'b1)) u_rise (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   (cell_out),
      .en    (cfg_rise_en),
      .clr   (clr_rise),
      .pulse (rise_pulse),
      .flag  (rise_flag)
   );

   lcell_edge #(.RISING(1'b0)) u_fall (
      .clk   (clk),
      .rst_n (rst_n),
      .sig   (cell_out),
      .en    (cfg_fall_en),
      .clr   (clr_fall),
      .pulse (fall_pulse),
      .flag  (fall_flag)
   );

   // R8: the two event sources never fire together
   a_r8_events_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rise_pulse && fall_pulse));

endmodule

// File: tb/lcell_top_tb.sv
module lcell_top_tb;

   localparam int unsigned PERIOD = 10;
   localparam int unsigned SRC_W = 32;
   localparam int unsigned NCAND = 8;
   localparam int unsigned SELW = 5;
   localparam int unsigned NG = 4;

   // {mode[2:0], g4 g3 g2 g1, out_pol, expected}
   localparam logic [8:0] VEC [12] = '{
      9'b000_0011_0_1, 9'b000_1100_0_1, 9'b000_0101_0_0, 9'b000_1010_1_1,
      9'b001_0001_0_1, 9'b001_0101_0_0, 9'b001_0000_0_0, 9'b001_1000_1_0,
      9'b010_1111_0_1, 9'b010_0111_0_0, 9'b010_1111_1_0, 9'b110_1111_0_0
   };

   logic clk = 1'b0;
   logic rst_n;
   logic [SRC_W-1:0] src_bus;
   logic [NG*NCAND*SELW-1:0] cfg_sel;
   logic [NG*NCAND-1:0] cfg_en_true, cfg_en_inv;
   logic [NG-1:0] cfg_gate_pol;
   logic [2:0] cfg_mode;
   logic cfg_out_pol, cfg_pin_oe, cfg_rise_en, cfg_fall_en, clr_rise, clr_fall;
   logic cell_out, pin_out, rise_pulse, fall_pulse, rise_flag, fall_flag;

   int n_checks = 0;
   int n_err = 0;

   always #(PERIOD/2) clk = ~clk;

   lcell_top u_dut (
      .clk(clk), .rst_n(rst_n), .src_bus(src_bus), .cfg_sel(cfg_sel),
      .cfg_en_true(cfg_en_true), .cfg_en_inv(cfg_en_inv),
      .cfg_gate_pol(cfg_gate_pol), .cfg_mode(cfg_mode),
      .cfg_out_pol(cfg_out_pol), .cfg_pin_oe(cfg_pin_oe),
      .cfg_rise_en(cfg_rise_en), .cfg_fall_en(cfg_fall_en),
      .clr_rise(clr_rise), .clr_fall(clr_fall), .cell_out(cell_out),
      .pin_out(pin_out), .rise_pulse(rise_pulse), .fall_pulse(fall_pulse),
      .rise_flag(rise_flag), .fall_flag(fall_flag)
   );

   task automatic check(input string req, input logic act, input logic exp);
      n_checks++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   // gate k uses candidate 0 = bus line k, true form
   task automatic simple_cfg();
      cfg_sel = '0;
      cfg_en_true = '0;
      cfg_en_inv = '0;
      cfg_gate_pol = '0;
      for (int k = 0; k < NG; k++) begin
         cfg_sel[k*NCAND*SELW +: SELW] = SELW'(k);
         cfg_en_true[k*NCAND] = 1'b1;
      end
   endtask

   task automatic summary();
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
   endtask

   initial begin
      #(PERIOD*100000);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      rst_n = 1'b0;
      src_bus = '0;
      simple_cfg();
      cfg_mode = 3'd0;
      cfg_out_pol = 1'b0; cfg_pin_oe = 1'b1;
      cfg_rise_en = 1'b0; cfg_fall_en = 1'b0;
      clr_rise = 1'b0; clr_fall = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      tick();

      // R11 reset state
      check("R11 reset cell_out", cell_out, 1'b0);
      check("R11 reset rise_flag", rise_flag, 1'b0);
      check("R11 reset fall_flag", fall_flag, 1'b0);
      check("R11 reset rise_pulse", rise_pulse, 1'b0);

      // R4 / R8 vector table
      for (int i = 0; i < 12; i++) begin
         cfg_mode = VEC[i][8:6];
         src_bus[3:0] = VEC[i][5:2];
         cfg_out_pol = VEC[i][1];
         #1;
         check($sformatf("R4 vector %0d cell_out", i), cell_out, VEC[i][0]);
         check($sformatf("R8 vector %0d pin_out", i), pin_out, VEC[i][0]);
         @(negedge clk);
      end
      cfg_out_pol = 1'b0;

      // R8 pin enable off
      cfg_mode = 3'd2; src_bus = 32'hF; cfg_pin_oe = 1'b0; #1;
      check("R8 oe off cell_out", cell_out, 1'b1);
      check("R8 oe off pin_out", pin_out, 1'b0);
      cfg_pin_oe = 1'b1;

      // R3 empty gates with polarity
      cfg_en_true = '0; cfg_gate_pol = 4'b1111; src_bus = '0; #1;
      check("R3 empty gates inverted", cell_out, 1'b1);
      cfg_gate_pol = 4'b1110; #1;
      check("R3 empty gate gives 0", cell_out, 1'b0);

      // R1 candidate 7 of gate 0 selects line 31
      cfg_gate_pol = 4'b1110;
      cfg_sel[7*SELW +: SELW] = 5'd31;
      cfg_en_true[7] = 1'b1;
      src_bus = 32'h0000_0001; #1;
      check("R1 line 31 low", cell_out, 1'b0);
      src_bus = 32'h8000_0000; #1;
      check("R1 line 31 high", cell_out, 1'b1);

      // R2 inverted form, both forms, OR of terms
      cfg_en_true = '0;
      cfg_sel[2*SELW +: SELW] = 5'd20;
      cfg_en_inv[2] = 1'b1;
      src_bus = '0; #1;
      check("R2 inverted form of 0", cell_out, 1'b1);
      src_bus = 32'h0010_0000; #1;
      check("R2 inverted form of 1", cell_out, 1'b0);
      cfg_en_true[2] = 1'b1; #1;
      check("R2 both forms", cell_out, 1'b1);
      cfg_en_true = '0; cfg_en_inv = '0;
      cfg_sel[0 +: SELW] = 5'd5; cfg_sel[SELW +: SELW] = 5'd6;
      cfg_en_true[1:0] = 2'b11;
      src_bus = 32'h40; #1;
      check("R2 OR of terms one set", cell_out, 1'b1);
      src_bus = 32'h0; #1;
      check("R2 OR of terms none set", cell_out, 1'b0);

      // R9 / R10 edges
      simple_cfg(); cfg_mode = 3'd0; src_bus = '0;
      cfg_rise_en = 1'b1; cfg_fall_en = 1'b0;
      tick();
      src_bus[3:0] = 4'b0011;
      tick();
      check("R9 rise pulse", rise_pulse, 1'b1);
      check("R10 rise flag set", rise_flag, 1'b1);
      tick();
      check("R9 rise pulse one cycle", rise_pulse, 1'b0);
      check("R10 rise flag held", rise_flag, 1'b1);
      src_bus[3:0] = 4'b0000;
      tick();
      check("R9 fall disabled pulse", fall_pulse, 1'b0);
      check("R9 fall disabled flag", fall_flag, 1'b0);
      clr_rise = 1'b1;
      tick();
      check("R10 rise flag cleared", rise_flag, 1'b0);
      src_bus[3:0] = 4'b0011;
      tick();
      check("R10 set wins over clear", rise_flag, 1'b1);
      tick();
      check("R10 clear after event", rise_flag, 1'b0);
      clr_rise = 1'b0;
      cfg_fall_en = 1'b1;
      src_bus[3:0] = 4'b0000;
      tick();
      check("R9 fall pulse", fall_pulse, 1'b1);
      check("R10 fall flag", fall_flag, 1'b1);
      clr_fall = 1'b1; tick(); clr_fall = 1'b0;
      check("R10 fall flag cleared", fall_flag, 1'b0);

      // R5 set/reset store
      cfg_mode = 3'd3;
      src_bus[3:0] = 4'b0100; tick();
      check("R5 reset", cell_out, 1'b0);
      src_bus[3:0] = 4'b0001; tick();
      check("R5 set", cell_out, 1'b1);
      src_bus[3:0] = 4'b0000; tick();
      check("R5 hold", cell_out, 1'b1);
      src_bus[3:0] = 4'b1010; tick();
      check("R5 reset wins", cell_out, 1'b0);

      // R6 D store
      cfg_mode = 3'd4;
      src_bus[3:0] = 4'b0100; tick();
      src_bus[3:0] = 4'b0010; tick();
      check("R6 no load without g1 rise", cell_out, 1'b0);
      src_bus[3:0] = 4'b0011; tick();
      check("R6 load on g1 rise", cell_out, 1'b1);
      src_bus[3:0] = 4'b0001; tick();
      check("R6 no load while g1 high", cell_out, 1'b1);
      src_bus[3:0] = 4'b0000; tick();
      src_bus[3:0] = 4'b0001; tick();
      check("R6 load 0", cell_out, 1'b0);
      src_bus[3:0] = 4'b1000; tick();
      check("R6 set", cell_out, 1'b1);
      src_bus[3:0] = 4'b1100; tick();
      check("R6 clear over set", cell_out, 1'b0);

      // R7 JK store
      cfg_mode = 3'd5;
      src_bus[3:0] = 4'b0100; tick();
      check("R7 clear", cell_out, 1'b0);
      src_bus[3:0] = 4'b1010; tick();
      src_bus[3:0] = 4'b1011; tick();
      check("R7 toggle to 1", cell_out, 1'b1);
      src_bus[3:0] = 4'b1010; tick();
      src_bus[3:0] = 4'b1011; tick();
      check("R7 toggle to 0", cell_out, 1'b0);
      src_bus[3:0] = 4'b0010; tick();
      src_bus[3:0] = 4'b0011; tick();
      check("R7 J sets", cell_out, 1'b1);
      src_bus[3:0] = 4'b1000; tick();
      src_bus[3:0] = 4'b1001; tick();
      check("R7 K clears", cell_out, 1'b0);
      src_bus[3:0] = 4'b0000; tick();
      src_bus[3:0] = 4'b0001; tick();
      check("R7 hold", cell_out, 1'b0);

      // R11 no false edge when leaving reset with output high
      cfg_mode = 3'd0; src_bus = '0; cfg_out_pol = 1'b1;
      cfg_rise_en = 1'b1; cfg_fall_en = 1'b1;
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      tick(); tick();
      check("R11 no rise after reset", rise_flag, 1'b0);
      cfg_out_pol = 1'b0;
      tick();
      check("R8 polarity change seen as fall", fall_flag, 1'b1);

      // R11 no false g1 rising after reset
      cfg_mode = 3'd4; src_bus[3:0] = 4'b0011;
      rst_n = 1'b0; @(negedge clk); rst_n = 1'b1;
      tick(); tick();
      check("R11 no load after reset", cell_out, 1'b0);

      summary();
      $finish;
   end

endmodule